// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of an external memory bus: the address-latch strobe, which tells an external latch when to capture the low address byte, and the active-low program-store read strobe, which enables external program memory onto the bus. It runs from the oscillator clock. A machine cycle is a fixed number of oscillator clocks, split into two equal halves. The address-latch strobe pulses once in each half, so it runs at one sixth of the oscillator rate with the default twelve-clock cycle. It can be switched off to cut emissions. While it is off, the output is parked high, and it still pulses for the instructions that need the bus.

The read strobe pulses once in each half while code executes from external memory. When a machine cycle carries an external data transfer, the bus belongs to the data access. The read strobe then stays idle for the whole cycle, and the first latch pulse of that cycle is dropped. All mode inputs are captured once, on the clock edge that opens a machine cycle. They govern that whole cycle. The block also brings out the phase count and markers for the cycle start and the half-cycle point, so that neighbouring logic can align to them.

Top module: `bus_strobe_gen`

## Requirements
- R1: `phase` counts 0 to CYCLE_LEN-1 and then wraps to 0, advancing by one each clock. `cyc_start` is high exactly when `phase` is 0. `half_start` is high exactly when `phase` is CYCLE_LEN/2.
- R2: In a cycle that has no data access and ALE not parked, `ale` is high for ALE_HIGH clocks from phase 0 and for ALE_HIGH clocks from phase CYCLE_LEN/2. It is low in every other phase (defaults: phases 0,1 and 6,7).
- R3: In a cycle marked as an external data access, the pulse of the first half (from phase 0) is dropped and the pulse of the second half is kept.
- R4: With external execution and no data access, `psen_n` is low for RD_LOW clocks starting RD_GAP clocks after each ALE pulse ends. The default windows are phases 3 to 5 and 9 to 11. It is high in every other phase.
- R5: In a cycle marked as an external data access, `psen_n` stays high for the whole cycle.
- R6: When external execution is not set, `psen_n` stays high.
- R7: When `ale_off` is set and neither `ext_exec` nor `xfer_insn` is set, `ale` is held high for the whole cycle.
- R8: When `ale_off` is set and `xfer_insn` is set, `ale` pulses as in R2 and R3.
- R9: `ale_off` has no effect while `ext_exec` is set.
- R10: `ext_data_cyc`, `ext_exec`, `xfer_insn` and `ale_off` are sampled only on the clock edge where `phase` becomes 0. A change later in the cycle has no effect until the next cycle.
- R11: While `rst` is high, `ale` is low, `psen_n` is high and `phase` holds CYCLE_LEN-1. The first edge after release starts a cycle at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_data_cyc | input | 1 | Coming cycle is an external data access |
| ext_exec | input | 1 | Code executes from external program memory |
| xfer_insn | input | 1 | Current instruction is a data move or table read that needs ALE |
| ale_off | input | 1 | ALE disable control bit |
| phase | output | $clog2(CYCLE_LEN) | Oscillator phase within the machine cycle |
| cyc_start | output | 1 | High in phase 0 |
| half_start | output | 1 | High in the first phase of the second half |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |

## Verification
The bench builds the block with its default timing: a twelve-clock cycle, two-clock latch pulses, a one-clock gap and three-clock read pulses. Under these values the read windows end exactly on the last phase of each half, so the wrap from the last phase to phase 0 is exercised with the read strobe active. All sixteen combinations of the four mode inputs are walked through. Some cycles flip every mode input in the middle of the cycle, and a reset is applied in the middle of a run, so the once-per-cycle sampling and the restart at phase 0 are both reached.

// File: rtl/bstrb_pkg.sv
package bstrb_pkg;

    typedef int unsigned uint_t;

    // Mode captured at the start of each machine cycle
    typedef struct packed {
        logic data_cyc;   // cycle carries an external data transfer
        logic ext_exec;   // code runs from external program memory
        logic ale_grant;  // instruction needs ALE even when it is switched off
        logic ale_off;    // ALE switched off by control bit
    } cyc_mode_t;

    typedef enum logic [0:0] {
        ALE_PULSE = 1'b0,
        ALE_PARK  = 1'b1
    } ale_sel_e;

    // True when ph lies in [first, first+len)
    function automatic logic in_win(uint_t ph, uint_t first, uint_t len);
        return (ph >= first) && (ph < first + len);
    endfunction

    function automatic ale_sel_e pick_ale(cyc_mode_t m);
        if (m.ale_off && !m.ext_exec && !m.ale_grant)
            return ALE_PARK;
        return ALE_PULSE;
    endfunction

endpackage

// File: rtl/bstrb_phase.sv
module bstrb_phase #(
    parameter int CYCLE_LEN = 12,
    localparam int PW = $clog2(CYCLE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase,
    output logic          wrap
);
    localparam logic [PW-1:0] LAST = PW'(CYCLE_LEN - 1);

    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst)
            ph_q <= LAST;
        else if (ph_q == LAST)
            ph_q <= '0;
        else
            ph_q <= ph_q + 1'b1;
    end

    assign phase = ph_q;
    assign wrap  = (ph_q == LAST);

endmodule

// File: rtl/bstrb_mode.sv
module bstrb_mode
    import bstrb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wrap,
    input  logic      ext_data_cyc,
    input  logic      ext_exec,
    input  logic      xfer_insn,
    input  logic      ale_off,
    output cyc_mode_t mode
);
    cyc_mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wrap)
            mode_q <= '{data_cyc: ext_data_cyc, ext_exec: ext_exec,
                        ale_grant: xfer_insn, ale_off: ale_off};
    end

    assign mode = mode_q;

endmodule

// File: rtl/bstrb_shape.sv
module bstrb_shape
    import bstrb_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int ALE_HIGH  = 2,
    parameter int RD_GAP    = 1,
    parameter int RD_LOW    = 3,
    localparam int PW       = $clog2(CYCLE_LEN),
    localparam int HALF     = CYCLE_LEN / 2,
    localparam int RD_FIRST = ALE_HIGH + RD_GAP
) (
    input  logic          rst,
    input  logic [PW-1:0] phase,
    input  cyc_mode_t     mode,
    output logic          cyc_start,
    output logic          half_start,
    output logic          ale,
    output logic          psen_n
);
    logic [1:0] ale_win;
    logic [1:0] ale_keep;
    logic [1:0] rd_win;
    ale_sel_e   sel;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign ale_win[h] = in_win(uint_t'(phase), uint_t'(h * HALF), uint_t'(ALE_HIGH));
        assign rd_win[h]  = in_win(uint_t'(phase), uint_t'(h * HALF + RD_FIRST), uint_t'(RD_LOW));
        if (h == 0) begin : g_first
            assign ale_keep[h] = !mode.data_cyc;
        end else begin : g_second
            assign ale_keep[h] = 1'b1;
        end
    end

    always_comb begin
        sel = pick_ale(mode);
        if (rst)
            ale = 1'b0;
        else if (sel == ALE_PARK)
            ale = 1'b1;
        else
            ale = |(ale_win & ale_keep);
    end

    always_comb begin
        psen_n = 1'b1;
        if (!rst && mode.ext_exec && !mode.data_cyc)
            psen_n = !(|rd_win);
    end

    assign cyc_start  = (phase == '0);
    assign half_start = (phase == PW'(HALF));

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bstrb_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int ALE_HIGH  = 2,
    parameter int RD_GAP    = 1,
    parameter int RD_LOW    = 3,
    localparam int PW       = $clog2(CYCLE_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_data_cyc,
    input  logic          ext_exec,
    input  logic          xfer_insn,
    input  logic          ale_off,
    output logic [PW-1:0] phase,
    output logic          cyc_start,
    output logic          half_start,
    output logic          ale,
    output logic          psen_n
);
    logic          wrap;
    logic [PW-1:0] ph;
    cyc_mode_t     mode_q;

    bstrb_phase #(.CYCLE_LEN(CYCLE_LEN)) i_phase (
        .clk  (clk),
        .rst  (rst),
        .phase(ph),
        .wrap (wrap)
    );

    bstrb_mode i_mode (
        .clk         (clk),
        .rst         (rst),
        .wrap        (wrap),
        .ext_data_cyc(ext_data_cyc),
        .ext_exec    (ext_exec),
        .xfer_insn   (xfer_insn),
        .ale_off     (ale_off),
        .mode        (mode_q)
    );

    bstrb_shape #(
        .CYCLE_LEN(CYCLE_LEN),
        .ALE_HIGH (ALE_HIGH),
        .RD_GAP   (RD_GAP),
        .RD_LOW   (RD_LOW)
    ) i_shape (
        .rst       (rst),
        .phase     (ph),
        .mode      (mode_q),
        .cyc_start (cyc_start),
        .half_start(half_start),
        .ale       (ale),
        .psen_n    (psen_n)
    );

    assign phase = ph;

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk
    import bstrb_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int ALE_HIGH  = 2,
    parameter int RD_GAP    = 1,
    parameter int RD_LOW    = 3,
    localparam int PW       = $clog2(CYCLE_LEN),
    localparam int HALF     = CYCLE_LEN / 2
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] phase,
    input logic          cyc_start,
    input logic          half_start,
    input logic          ale,
    input logic          psen_n,
    input cyc_mode_t     mode
);
    localparam logic [PW-1:0] LAST = PW'(CYCLE_LEN - 1);
    localparam logic [PW-1:0] RD0  = PW'(ALE_HIGH + RD_GAP);
    localparam logic [PW-1:0] RD1  = PW'(HALF + ALE_HIGH + RD_GAP);
    localparam logic [PW-1:0] AF0  = PW'(ALE_HIGH);
    localparam logic [PW-1:0] AF1  = PW'(HALF + ALE_HIGH);

    // R1: phase steps and wraps
    a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));
    a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase == LAST) |=> (phase == '0) && cyc_start);
    a_r1_markers: assert property (@(posedge clk) disable iff (rst)
        cyc_start |-> !half_start);

    // R2: ALE pulses end only at the pulse-end phases (or on leaving park at phase 0)
    a_r2_ale_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(ale) |-> (phase == AF0 || phase == AF1 || phase == '0));

    // R3: first pulse dropped in a data cycle
    a_r3_first_dropped: assert property (@(posedge clk) disable iff (rst)
        (mode.data_cyc && !mode.ale_off && phase == '0) |-> !ale);

    // R4: read strobe only starts at its window starts and never with ALE
    a_r4_rd_start: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |-> (phase == RD0 || phase == RD1) && !ale);

    // R5: no read strobe in a data cycle
    a_r5_rd_quiet: assert property (@(posedge clk) disable iff (rst)
        mode.data_cyc |-> psen_n);

    // R6: read strobe needs external execution
    a_r6_rd_exec: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> mode.ext_exec);

    // R7: parked ALE stays high
    a_r7_parked: assert property (@(posedge clk) disable iff (rst)
        (mode.ale_off && !mode.ext_exec && !mode.ale_grant) |-> ale);

    // R9: in external execution the second-half pulse always appears
    a_r9_exec_pulse: assert property (@(posedge clk) disable iff (rst)
        (mode.ext_exec && half_start) |-> ale);

    // R10: mode only moves at the cycle boundary
    a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |-> $stable(mode));

    // R11: idle outputs under reset
    always_comb begin
        if (rst) begin
            a_r11_reset_idle: assert (!ale && psen_n);
        end
    end

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
    .CYCLE_LEN(CYCLE_LEN),
    .ALE_HIGH (ALE_HIGH),
    .RD_GAP   (RD_GAP),
    .RD_LOW   (RD_LOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .cyc_start (cyc_start),
    .half_start(half_start),
    .ale       (ale),
    .psen_n    (psen_n),
    .mode      (mode_q)
);

// File: tb/test_bus_strobe_gen.sv
module test_bus_strobe_gen;

    localparam int CLK_P  = 10;
    localparam int CYC    = 12;
    localparam int HALF   = CYC / 2;
    localparam int A_HI   = 2;
    localparam int R_GAP  = 1;
    localparam int R_LOW  = 3;
    localparam int PW     = $clog2(CYC);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_data_cyc = 1'b0;
    logic ext_exec = 1'b0;
    logic xfer_insn = 1'b0;
    logic ale_off = 1'b0;
    logic [PW-1:0] phase;
    logic cyc_start, half_start, ale, psen_n;

    int n_run = 0;
    int n_fail = 0;

    // reference state
    int m_ph = CYC - 1;
    bit m_d = 0, m_x = 0, m_g = 0, m_o = 0;
    bit m_wig = 0;
    bit wig_now = 0;

    always #(CLK_P / 2) clk = ~clk;

    bus_strobe_gen #(
        .CYCLE_LEN(CYC), .ALE_HIGH(A_HI), .RD_GAP(R_GAP), .RD_LOW(R_LOW)
    ) i_bus_strobe_gen (
        .clk(clk), .rst(rst), .ext_data_cyc(ext_data_cyc), .ext_exec(ext_exec),
        .xfer_insn(xfer_insn), .ale_off(ale_off), .phase(phase),
        .cyc_start(cyc_start), .half_start(half_start), .ale(ale), .psen_n(psen_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (model phase %0d)",
                     req, what, act, exp, m_ph);
        end
    endtask

    // reference model update and comparison
    always @(posedge clk) begin
        bit exp_ale, exp_rd_n, park;
        string ta, tr;
        if (rst) begin
            m_ph = CYC - 1;
            m_d = 0; m_x = 0; m_g = 0; m_o = 0; m_wig = 0;
        end else if (m_ph == CYC - 1) begin
            m_ph = 0;
            m_d = ext_data_cyc; m_x = ext_exec; m_g = xfer_insn; m_o = ale_off;
            m_wig = wig_now;
        end else begin
            m_ph = m_ph + 1;
        end
        #(CLK_P / 4);
        park = m_o && !m_x && !m_g;
        if (rst) begin
            exp_ale = 0; exp_rd_n = 1; ta = "R11"; tr = "R11";
        end else begin
            if (park) exp_ale = 1;
            else if (m_ph < A_HI) exp_ale = !m_d;
            else exp_ale = (m_ph >= HALF && m_ph < HALF + A_HI);
            if (!m_x || m_d) exp_rd_n = 1;
            else exp_rd_n = !((m_ph >= A_HI + R_GAP && m_ph < A_HI + R_GAP + R_LOW) ||
                              (m_ph >= HALF + A_HI + R_GAP && m_ph < HALF + A_HI + R_GAP + R_LOW));
            if (m_wig) ta = "R10";
            else if (park) ta = "R7";
            else if (m_o && m_x) ta = "R9";
            else if (m_o && m_g) ta = "R8";
            else if (m_d) ta = "R3";
            else ta = "R2";
            if (m_wig) tr = "R10";
            else if (!m_x) tr = "R6";
            else if (m_d) tr = "R5";
            else tr = "R4";
        end
        check(ale === exp_ale, ta, "ale", int'(ale), int'(exp_ale));
        check(psen_n === exp_rd_n, tr, "psen_n", int'(psen_n), int'(exp_rd_n));
        check(int'(phase) == m_ph, rst ? "R11" : "R1", "phase", int'(phase), m_ph);
        check(cyc_start === (m_ph == 0), "R1", "cyc_start", int'(cyc_start), int'(m_ph == 0));
        check(half_start === (m_ph == HALF), "R1", "half_start", int'(half_start), int'(m_ph == HALF));
    end

    // Called at a negedge where the model sits in the last phase
    task automatic do_cycle(input bit d, input bit x, input bit g, input bit o, input bit wig);
        ext_data_cyc = d; ext_exec = x; xfer_insn = g; ale_off = o;
        wig_now = wig;
        repeat (CYC) begin
            @(negedge clk);
            if (wig && m_ph == 4) begin
                ext_data_cyc = !d; ext_exec = !x; xfer_insn = !g; ale_off = !o;
            end
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // named patterns
        do_cycle(0, 0, 0, 0, 0);   // R2 plain
        do_cycle(1, 0, 0, 0, 0);   // R3 data skip
        do_cycle(0, 1, 0, 0, 0);   // R4 read pulses
        do_cycle(1, 1, 0, 0, 0);   // R5 data in ext exec
        do_cycle(0, 1, 0, 0, 0);   // R4 again after data
        do_cycle(0, 0, 0, 1, 0);   // R7 parked
        do_cycle(0, 0, 0, 1, 0);   // R7 parked stays
        do_cycle(1, 0, 1, 1, 0);   // R8 grant with data
        do_cycle(0, 0, 1, 1, 0);   // R8 grant
        do_cycle(0, 1, 0, 1, 0);   // R9 off ignored
        do_cycle(1, 1, 0, 1, 0);   // R9 with data
        do_cycle(0, 0, 0, 1, 1);   // R10 mid-cycle flip
        do_cycle(0, 1, 0, 0, 1);   // R10
        do_cycle(1, 1, 1, 0, 1);   // R10
        for (int i = 0; i < 16; i++)
            do_cycle(i[3], i[2], i[1], i[0], (i % 3) == 0);
        // R11 reset in the middle of a run
        do_cycle(0, 1, 0, 0, 0);
        ext_exec = 1;
        repeat (5) @(negedge clk);
        rst = 1;
        repeat (7) @(negedge clk);
        rst = 0;
        do_cycle(0, 1, 0, 0, 0);
        do_cycle(1, 0, 0, 0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule